// File: doc/BRIEF.md
# Flow-Controlled 32-bit Chip-to-Chip Link Port

This block is one chip's end of a full-duplex, point-to-point link that joins two identical switch chips. Two chips each hold one copy of the block and face each other, and the wiring is symmetric. On the outgoing side, the local core pushes 32-bit words into a transmit FIFO. The transmitter drains that FIFO onto a registered 32-bit output bus. It drives a data-enable strobe that marks each valid word, and it forwards its clock beside the bus. The link is sized for 100 MHz, which gives 3.2 Gbps in each direction.

On the incoming side, a word is taken on a rising edge only while the peer's enable is high. Captured words go into a receive FIFO, from which the local core pops them. Each direction has a reverse flow-control wire. The receiver raises its flow-control output once its FIFO reaches a high-water mark. It keeps that output raised until the FIFO falls below a lower mark. The transmitter stops launching words within two cycles of seeing the peer's flow-control input high.

The high-water mark leaves enough free entries to absorb every word already on its way when flow control is raised. Those words sit in the capture register, the peer's output register and the peer's flow-control sampling stage. Crossing between the two clock domains is modelled here with one shared clock. The forwarded clock output is that clock.

Top module: `chiplink_port`

## Requirements
- R1: In the first cycle after synchronous reset is released, `lnk_den_out` and `lnk_fc_out` are low, `rx_valid` is low and `tx_ready` is high.
- R2: A word accepted on the push side (`tx_valid` and `tx_ready` high at a rising edge) appears on `lnk_dout` with `lnk_den_out` high after the next rising edge, provided flow control is low. Words leave in the order they were pushed, with none lost or repeated.
- R3: If `lnk_fc_in` is high at rising edge k, then `lnk_den_out` is low after edge k+1 and stays low for as long as `lnk_fc_in` stays high. At most the one word launched at edge k leaves after flow control is sampled.
- R4: A word on `lnk_din` with `lnk_den_in` high at rising edge e is written into the receive FIFO at edge e+1. It is then offered on `rx_data` with `rx_valid` high. Bus values seen while `lnk_den_in` is low are discarded. `rx_valid`/`rx_ready` pops in arrival order.
- R5: `lnk_fc_out` goes high one cycle after the receive FIFO first holds 12 or more words (FC_ON, with a 16-entry receive FIFO).
- R6: Once high, `lnk_fc_out` stays high while the receive FIFO holds 8 or more words (FC_OFF). It goes low one cycle after the count drops below 8.
- R7: When the peer obeys R3, the receive FIFO never receives a write while it is full. The four words that can still be in flight after flow control is raised fit in the 4 entries above FC_ON.
- R8: When the port is looped back onto itself under random push and pop stalls, every pushed word is delivered once, in order.
- R9: `tx_ready` is low exactly while the 16-entry transmit FIFO is full. A push offered while it is low is not taken.
- R10: `lnk_clk_out` follows the port clock, high in the high phase and low in the low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, also forwarded on the link |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Local core offers a word to send |
| tx_data | input | 32 | Word to send |
| tx_ready | output | 1 | Transmit FIFO has room |
| lnk_dout | output | 32 | Outgoing link data bus |
| lnk_clk_out | output | 1 | Forwarded clock for the outgoing bus |
| lnk_den_out | output | 1 | Outgoing word valid strobe |
| lnk_fc_in | input | 1 | Peer asks this port to pause |
| lnk_din | input | 32 | Incoming link data bus |
| lnk_den_in | input | 1 | Incoming word valid strobe |
| lnk_fc_out | output | 1 | This port asks the peer to pause |
| rx_valid | output | 1 | Receive FIFO holds a word |
| rx_data | output | 32 | Oldest received word |
| rx_ready | input | 1 | Local core takes the offered word |

## Verification
The overflow property assumes a peer that honours the two-cycle pause rule. The bench meets this by driving the receive bus directly only in bursts of at most 12 words, and by otherwise looping the port's own transmitter back into its receiver. The pause property assumes `lnk_fc_in` is a registered signal, so its value two edges back is meaningful. The bench changes it only just after a rising edge. Push and pop stimulus also changes only after an edge, so the hysteresis and capture timing are observed edge by edge.

// File: rtl/chiplink_pkg.sv
package chiplink_pkg;

    localparam int LINK_W_DEF  = 32;
    localparam int FIFO_D_DEF  = 16;
    localparam int FC_ON_DEF   = 12;
    localparam int FC_OFF_DEF  = 8;

    typedef enum logic {
        FC_OPEN = 1'b0,
        FC_HALT = 1'b1
    } fc_state_e;

    // Hysteresis step: halt at or above the high mark, reopen below the low mark.
    function automatic fc_state_e fc_next(input fc_state_e cur,
                                          input logic at_high,
                                          input logic below_low);
        if (at_high)
            return FC_HALT;
        else if (below_low)
            return FC_OPEN;
        return cur;
    endfunction

endpackage

// File: rtl/chiplink_fifo.sv
module chiplink_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic                     rd_en,
    output logic [WIDTH-1:0]         rd_data,
    output logic [$clog2(DEPTH):0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic             do_wr, do_rd;

    assign do_wr   = wr_en && (count != FULL_C);
    assign do_rd   = rd_en && (count != '0);
    assign rd_data = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_wr) wp <= wp + 1'b1;
            if (do_rd) rp <= rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/chiplink_tx.sv
module chiplink_tx #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             q_empty,
    input  logic [WIDTH-1:0] q_head,
    output logic             q_pop,
    input  logic             fc_in,
    output logic [WIDTH-1:0] dout,
    output logic             den
);
    logic fc_q;

    // Launch only on the registered copy of the peer's pause request.
    assign q_pop = !q_empty && !fc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fc_q <= 1'b1;
            den  <= 1'b0;
            dout <= '0;
        end else begin
            fc_q <= fc_in;
            den  <= q_pop;
            if (q_pop)
                dout <= q_head;
        end
    end
endmodule

// File: rtl/chiplink_rx.sv
module chiplink_rx
    import chiplink_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int DEPTH  = 16,
    parameter int FC_ON  = 12,
    parameter int FC_OFF = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [WIDTH-1:0]       din,
    input  logic                   den_in,
    input  logic [$clog2(DEPTH):0] q_count,
    output logic                   q_push,
    output logic [WIDTH-1:0]       q_data,
    output logic                   fc_out
);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] ON_C  = CW'(FC_ON);
    localparam logic [CW-1:0] OFF_C = CW'(FC_OFF);

    logic      cap_en;
    logic [WIDTH-1:0] cap_data;
    fc_state_e fc_state;

    assign q_push = cap_en;
    assign q_data = cap_data;
    assign fc_out = (fc_state == FC_HALT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_en   <= 1'b0;
            cap_data <= '0;
            fc_state <= FC_OPEN;
        end else begin
            cap_en   <= den_in;
            if (den_in)
                cap_data <= din;
            fc_state <= fc_next(fc_state, q_count >= ON_C, q_count < OFF_C);
        end
    end
endmodule

// File: rtl/chiplink_port.sv
module chiplink_port
    import chiplink_pkg::*;
#(
    parameter int LINK_W   = LINK_W_DEF,
    parameter int TX_DEPTH = FIFO_D_DEF,
    parameter int RX_DEPTH = FIFO_D_DEF,
    parameter int FC_ON    = FC_ON_DEF,
    parameter int FC_OFF   = FC_OFF_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_valid,
    input  logic [LINK_W-1:0] tx_data,
    output logic              tx_ready,
    output logic [LINK_W-1:0] lnk_dout,
    output logic              lnk_clk_out,
    output logic              lnk_den_out,
    input  logic              lnk_fc_in,
    input  logic [LINK_W-1:0] lnk_din,
    input  logic              lnk_den_in,
    output logic              lnk_fc_out,
    output logic              rx_valid,
    output logic [LINK_W-1:0] rx_data,
    input  logic              rx_ready
);
    localparam int TX_CW = $clog2(TX_DEPTH) + 1;
    localparam int RX_CW = $clog2(RX_DEPTH) + 1;

    logic [TX_CW-1:0]  tx_count;
    logic [RX_CW-1:0]  rx_count;
    logic              tx_empty, tx_pop, rx_push, rx_full;
    logic [LINK_W-1:0] tx_head, rx_wdata;

    assign lnk_clk_out = clk;
    assign tx_ready    = (tx_count != TX_CW'(TX_DEPTH));
    assign tx_empty    = (tx_count == '0);
    assign rx_valid    = (rx_count != '0);
    assign rx_full     = (rx_count == RX_CW'(RX_DEPTH));

    chiplink_fifo #(.WIDTH(LINK_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .wr_en(tx_valid && tx_ready), .wr_data(tx_data),
        .rd_en(tx_pop), .rd_data(tx_head), .count(tx_count)
    );

    chiplink_tx #(.WIDTH(LINK_W)) u_tx (
        .clk(clk), .rst(rst),
        .q_empty(tx_empty), .q_head(tx_head), .q_pop(tx_pop),
        .fc_in(lnk_fc_in), .dout(lnk_dout), .den(lnk_den_out)
    );

    chiplink_rx #(.WIDTH(LINK_W), .DEPTH(RX_DEPTH), .FC_ON(FC_ON), .FC_OFF(FC_OFF)) u_rx (
        .clk(clk), .rst(rst),
        .din(lnk_din), .den_in(lnk_den_in), .q_count(rx_count),
        .q_push(rx_push), .q_data(rx_wdata), .fc_out(lnk_fc_out)
    );

    chiplink_fifo #(.WIDTH(LINK_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .wr_en(rx_push), .wr_data(rx_wdata),
        .rd_en(rx_valid && rx_ready), .rd_data(rx_data), .count(rx_count)
    );
endmodule

// File: rtl/chiplink_port_chk.sv
module chiplink_port_chk #(
    parameter int CW  = 5,
    parameter int HI  = 12,
    parameter int LO  = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          lnk_fc_in,
    input logic          lnk_den_out,
    input logic          lnk_fc_out,
    input logic          tx_empty,
    input logic          rx_push,
    input logic          rx_full,
    input logic [CW-1:0] rx_count
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!lnk_den_out && !lnk_fc_out));

    assert_launch_from_queue_R2: assert property (@(posedge clk) disable iff (rst)
        lnk_den_out |-> $past(!tx_empty));

    assert_pause_R3: assert property (@(posedge clk) disable iff (rst)
        $past(lnk_fc_in, 2) |-> !lnk_den_out);

    assert_fc_rise_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_count >= CW'(HI)) |=> lnk_fc_out);

    assert_fc_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (lnk_fc_out && rx_count >= CW'(LO)) |=> lnk_fc_out);

    assert_fc_fall_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_count < CW'(LO)) |=> !lnk_fc_out);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        !(rx_push && rx_full));
endmodule

bind chiplink_port chiplink_port_chk #(.CW(RX_CW), .HI(FC_ON), .LO(FC_OFF)) u_chk (
    .clk(clk), .rst(rst), .lnk_fc_in(lnk_fc_in), .lnk_den_out(lnk_den_out),
    .lnk_fc_out(lnk_fc_out), .tx_empty(tx_empty), .rx_push(rx_push),
    .rx_full(rx_full), .rx_count(rx_count)
);

// File: tb/test_chiplink_port.sv
`timescale 1ns/1ps
module test_chiplink_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_valid = 1'b0, tx_ready;
    logic [31:0] tx_data = '0;
    logic [31:0] lnk_dout, lnk_din, rx_data;
    logic        lnk_clk_out, lnk_den_out, lnk_fc_in, lnk_den_in, lnk_fc_out;
    logic        rx_valid, rx_ready = 1'b0;

    logic        loop_mode = 1'b0;
    logic [31:0] din_drv = '0;
    logic        den_drv = 1'b0, fc_drv = 1'b0;

    assign lnk_din    = loop_mode ? lnk_dout    : din_drv;
    assign lnk_den_in = loop_mode ? lnk_den_out : den_drv;
    assign lnk_fc_in  = loop_mode ? lnk_fc_out  : fc_drv;

    always #2.5 clk = ~clk;

    chiplink_port i_chiplink_port (
        .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .lnk_dout(lnk_dout), .lnk_clk_out(lnk_clk_out), .lnk_den_out(lnk_den_out),
        .lnk_fc_in(lnk_fc_in), .lnk_din(lnk_din), .lnk_den_in(lnk_den_in),
        .lnk_fc_out(lnk_fc_out), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
    );

    int checks = 0, fails = 0, pushed = 0;
    bit fc_seen = 1'b0;
    logic [31:0] txq[$];
    logic [31:0] rxq[$];

    // Record every beat, push and pop half a cycle before the edge that acts on it.
    always @(negedge clk) begin
        if (!rst) begin
            if (lnk_den_out) txq.push_back(lnk_dout);
            if (rx_valid && rx_ready) rxq.push_back(rx_data);
            if (tx_valid && tx_ready) pushed++;
            if (lnk_fc_out) fc_seen = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Compare a queue against base+i for i in [0,n), counting mismatches.
    task automatic chk_seq(ref logic [31:0] q[$], input logic [31:0] base, input int n, input string req);
        int bad = 0;
        chk(q.size() == n, {req, " count"}, q.size(), n);
        for (int i = 0; i < q.size() && i < n; i++)
            if (q[i] !== base + 32'(i)) bad++;
        chk(bad == 0, {req, " order"}, bad, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int snap, nexp, bad, k;
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        chk(lnk_den_out == 0, "R1 den_out", lnk_den_out, 0);
        chk(lnk_fc_out == 0,  "R1 fc_out", lnk_fc_out, 0);
        chk(rx_valid == 0,    "R1 rx_valid", rx_valid, 0);
        chk(tx_ready == 1,    "R1 tx_ready", tx_ready, 1);

        // R10 forwarded clock follows the port clock
        @(posedge clk); #1;
        chk(lnk_clk_out == 1, "R10 high phase", lnk_clk_out, 1);
        #2.5;
        chk(lnk_clk_out == 0, "R10 low phase", lnk_clk_out, 0);
        tick();

        // R2 single-word latency
        txq.delete();
        tx_valid = 1; tx_data = 32'hA5A5_0001;
        tick();
        tx_valid = 0;
        chk(lnk_den_out == 0, "R2 not yet launched", lnk_den_out, 0);
        tick();
        chk(lnk_den_out == 1 && lnk_dout == 32'hA5A5_0001, "R2 launch", lnk_dout, 32'hA5A5_0001);
        tick();
        chk(lnk_den_out == 0, "R2 single beat", lnk_den_out, 0);

        // R3 paused before any push
        fc_drv = 1; tick(); tick();
        txq.delete();
        for (int i = 0; i < 8; i++) begin
            tx_valid = 1; tx_data = 32'h1000 + 32'(i); tick();
        end
        tx_valid = 0;
        repeat (5) tick();
        chk(txq.size() == 0, "R3 no launch while paused", txq.size(), 0);
        fc_drv = 0;
        repeat (12) tick();
        chk_seq(txq, 32'h1000, 8, "R2 release");

        // R3 pause in mid-stream: fc sampled at the 5th push edge, 4 words get out
        txq.delete();
        snap = -1;
        for (int i = 0; i < 12; i++) begin
            tx_valid = 1; tx_data = 32'h1100 + 32'(i);
            if (i == 4) fc_drv = 1;
            tick();
            if (i == 5) snap = txq.size();
        end
        tx_valid = 0;
        chk(snap == 4, "R3 words before pause", snap, 4);
        repeat (6) tick();
        chk(txq.size() == snap, "R3 stays paused", txq.size(), snap);
        fc_drv = 0;
        repeat (20) tick();
        chk_seq(txq, 32'h1100, 12, "R2 mid-stream");

        // R9 transmit FIFO full
        fc_drv = 1; tick(); tick();
        pushed = 0;
        for (int i = 0; i < 20; i++) begin
            tx_valid = 1; tx_data = 32'h2000 + 32'(pushed); tick();
        end
        tx_valid = 0;
        chk(pushed == 16, "R9 accepted count", pushed, 16);
        chk(tx_ready == 0, "R9 ready low when full", tx_ready, 0);
        txq.delete();
        fc_drv = 0;
        repeat (25) tick();
        chk_seq(txq, 32'h2000, 16, "R9 drain");
        chk(tx_ready == 1, "R9 ready back", tx_ready, 1);

        // R4 capture latency
        den_drv = 1; din_drv = 32'h3333_0000; tick();
        den_drv = 0; din_drv = 32'hFFFF_FFFF;
        chk(rx_valid == 0, "R4 not yet written", rx_valid, 0);
        tick();
        chk(rx_valid == 1 && rx_data == 32'h3333_0000, "R4 written", rx_data, 32'h3333_0000);
        rx_ready = 1; tick(); rx_ready = 0;
        chk(rx_valid == 0, "R4 popped", rx_valid, 0);

        // R4 enable gating: only i%3 != 1 counts
        rxq.delete();
        rx_ready = 1;
        for (int i = 0; i < 20; i++) begin
            den_drv = (i % 3 != 1);
            din_drv = den_drv ? 32'h3000 + 32'(i) : 32'hDEAD_0000 + 32'(i);
            tick();
        end
        den_drv = 0;
        repeat (5) tick();
        rx_ready = 0;
        nexp = 0; bad = 0; k = 0;
        for (int i = 0; i < 20; i++) begin
            if (i % 3 != 1) begin
                if (k < rxq.size() && rxq[k] !== 32'h3000 + 32'(i)) bad++;
                k++; nexp++;
            end
        end
        chk(rxq.size() == nexp, "R4 gated count", rxq.size(), nexp);
        chk(bad == 0, "R4 gated order", bad, 0);

        // R5 / R6 hysteresis
        rxq.delete();
        for (int i = 0; i < 11; i++) begin
            den_drv = 1; din_drv = 32'h4000 + 32'(i); tick();
        end
        den_drv = 0;
        repeat (4) tick();
        chk(lnk_fc_out == 0, "R5 below mark at 11", lnk_fc_out, 0);
        den_drv = 1; din_drv = 32'h4000 + 32'd11; tick();
        den_drv = 0;
        chk(lnk_fc_out == 0, "R5 before write", lnk_fc_out, 0);
        tick();
        chk(lnk_fc_out == 0, "R5 same cycle as 12th write", lnk_fc_out, 0);
        tick();
        chk(lnk_fc_out == 1, "R5 raised at 12", lnk_fc_out, 1);
        rx_ready = 1; repeat (4) tick(); rx_ready = 0;
        tick();
        chk(lnk_fc_out == 1, "R6 held at 8", lnk_fc_out, 1);
        rx_ready = 1; tick(); rx_ready = 0;
        chk(lnk_fc_out == 1, "R6 one cycle after 7", lnk_fc_out, 1);
        tick();
        chk(lnk_fc_out == 0, "R6 dropped below 8", lnk_fc_out, 0);
        rx_ready = 1; repeat (10) tick(); rx_ready = 0;
        chk_seq(rxq, 32'h4000, 12, "R4 burst");

        // R7 / R8 loopback with random stalls, three pop densities
        loop_mode = 1;
        for (int r = 0; r < 3; r++) begin
            int dens = 1 + 4 * r;
            rxq.delete();
            pushed = 0;
            fc_seen = 0;
            for (int c = 0; c < 1500; c++) begin
                tx_valid = ($urandom % 10) < 7;
                tx_data  = 32'h0100_0000 * 32'(r) + 32'(pushed);
                rx_ready = ($urandom % 10) < 32'(dens);
                tick();
            end
            tx_valid = 0; rx_ready = 1;
            repeat (80) tick();
            chk_seq(rxq, 32'h0100_0000 * 32'(r), pushed, "R8 loopback");
            chk(rx_valid == 0, "R7 receive drained", rx_valid, 0);
            if (r == 0) chk(fc_seen, "R7 flow control engaged", fc_seen, 1);
        end
        rx_ready = 0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule